// File: doc/BRIEF.md
# Modbus RTU Request Frame Receiver

This block sits behind a UART receiver and assembles one Modbus RTU request at a time from the byte stream. Frame boundaries come from silent time on the line, not from delimiter bytes. A bit-time counter restarts on every received byte. A silence of at least 3.5 character times closes the current frame and readies the block for the next one. A silence of more than 1.5 character times between two bytes of the same frame marks that frame as broken.

The first byte of a frame is compared against a slave address taken from an input port. Only when it matches does the running CRC-16 over the frame decide acceptance. A frame that passes every check leaves as a single-cycle strobe carrying the function code, the 16-bit start register and the 16-bit quantity or data word. Any other frame is dropped silently: there is no strobe, the field outputs do not move, and there is no error signal. Character time is fixed at 11 bits. Both thresholds are rounded up to whole bit times: 17 bits for the mid-frame gap and 39 bits for the end of a frame.

Top module: `rtu_req_rx`

## Requirements
- R1: While reset is high and after it is released, `frame_valid` is 0 and `func_code`, `start_reg` and `reg_word` are 0. The line counts as silent, so the first byte after reset starts a frame.
- R2: An accepted frame gives exactly one one-cycle `frame_valid` pulse. In that cycle `func_code` is byte 1, `start_reg` is {byte 2, byte 3} and `reg_word` is {byte 4, byte 5}, with the high byte first (byte 0 is the address).
- R3: The pulse for a frame comes no earlier than 39 bit times (39*CLKS_PER_BIT clocks) after that frame's last byte. It comes no later than 2 bit times after that point.
- R4: A frame whose byte 0 differs from `slave_addr` is discarded.
- R5: A frame whose CRC fails is discarded. The CRC is reflected polynomial 0xA001 with seed 0xFFFF, taken over all 8 bytes, with the CRC low byte sent at byte 6 and the high byte at byte 7, so that the residue is zero. The field outputs change only in a cycle where `frame_valid` is 1.
- R6: Two bytes of one frame separated by at least 17 bit times but fewer than 39 make the whole frame discarded. Bytes closer than 17 bit times are accepted.
- R7: Only frames of exactly 8 bytes are accepted. Longer and shorter frames are discarded.
- R8: The address compared is the value on `slave_addr` when byte 0 arrives. Changing the port changes which frames are accepted.
- R9: A silence of 39 bit times ends any frame. The next byte starts a fresh frame, so a discarded frame never affects the following one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slave_addr | input | 8 | Address this slave answers to |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | One-cycle strobe, rx_data holds a new byte |
| frame_valid | output | 1 | One-cycle strobe for an accepted request |
| func_code | output | 8 | Function code of the last accepted request |
| start_reg | output | 16 | Start register of the last accepted request |
| reg_word | output | 16 | Quantity or data word of the last accepted request |

## Verification
The bench aims at the two silence thresholds. It sends a frame whose inner gap is just under 17 bit times, which must still be accepted, and one with a gap in the broken zone, which must be dropped. A receiver with a swapped or off-by-range comparison would accept the broken frame or lose the good one. It checks the strobe against a window around 39 bit times after the last byte, which catches a receiver that closes frames too early or counts clocks instead of bit times. It also sends frames one byte too long and too short, with a bad CRC, and for another address, and moves the address port, to catch a length check that only caps the count, a CRC that runs for foreign addresses, or outputs that move on rejected frames. A lone stray byte followed by a good frame shows whether leftover state leaks across a silent gap.

// File: rtl/rtu_rx_pkg.sv
package rtu_rx_pkg;

  localparam logic [15:0] CRC_POLY = 16'hA001;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;
  localparam int          REQ_BYTES = 8;

  typedef struct packed {
    logic [7:0]  func;
    logic [15:0] start;
    logic [15:0] word;
  } req_fields_t;

  // one byte through the reflected CRC-16, LSB first
  function automatic logic [15:0] crc_step(input logic [15:0] crc_in,
                                           input logic [7:0]  data);
    logic [15:0] acc;
    acc = crc_in ^ {8'h00, data};
    for (int k = 0; k < 8; k++) begin
      if (acc[0]) acc = (acc >> 1) ^ CRC_POLY;
      else        acc = acc >> 1;
    end
    return acc;
  endfunction

endpackage

// File: rtl/rtu_silence_timer.sv
module rtu_silence_timer #(
  parameter int CLKS_PER_BIT = 8,
  parameter int CHAR_BITS    = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic byte_stb,
  output logic gap_mid,
  output logic quiet
);
  localparam int T15_BITS = (CHAR_BITS * 3 + 1) / 2;
  localparam int T35_BITS = (CHAR_BITS * 7 + 1) / 2;
  localparam int DW       = $clog2(CLKS_PER_BIT + 1);
  localparam int SW       = $clog2(T35_BITS + 1);
  localparam logic [DW-1:0] DIV_LAST = DW'(CLKS_PER_BIT - 1);
  localparam logic [SW-1:0] T15_CNT  = SW'(T15_BITS);
  localparam logic [SW-1:0] T35_CNT  = SW'(T35_BITS);

  logic [DW-1:0] div_q;
  logic [SW-1:0] sil_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      sil_q <= T35_CNT;
    end else if (byte_stb) begin
      div_q <= '0;
      sil_q <= '0;
    end else if (div_q == DIV_LAST) begin
      div_q <= '0;
      if (sil_q != T35_CNT) sil_q <= sil_q + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign gap_mid = (sil_q >= T15_CNT);
  assign quiet   = (sil_q == T35_CNT);

endmodule

// File: rtl/rtu_crc16.sv
module rtu_crc16 (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic       upd,
  input  logic [7:0] data,
  output logic       zero
);
  import rtu_rx_pkg::*;

  logic [15:0] crc_q;

  always_ff @(posedge clk) begin
    if (rst)       crc_q <= CRC_SEED;
    else if (load) crc_q <= crc_step(CRC_SEED, data);
    else if (upd)  crc_q <= crc_step(crc_q, data);
  end

  assign zero = (crc_q == 16'h0000);

endmodule

// File: rtl/rtu_byte_store.sv
module rtu_byte_store #(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [7:0]         wdata,
  output logic [DEPTH*8-1:0] flat
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_out
    assign flat[g*8 +: 8] = mem[g];
  end

endmodule

// File: rtl/rtu_req_rx.sv
module rtu_req_rx #(
  parameter int CLKS_PER_BIT = 8,
  parameter int CHAR_BITS    = 11,
  parameter int FRAME_BYTES  = rtu_rx_pkg::REQ_BYTES
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  slave_addr,
  input  logic [7:0]  rx_data,
  input  logic        rx_valid,
  output logic        frame_valid,
  output logic [7:0]  func_code,
  output logic [15:0] start_reg,
  output logic [15:0] reg_word
);
  import rtu_rx_pkg::*;

  localparam int AW = $clog2(FRAME_BYTES);
  localparam int CW = $clog2(FRAME_BYTES + 2);
  localparam logic [CW-1:0] LEN_OK = CW'(FRAME_BYTES);

  logic gap_mid, quiet, crc_zero;
  logic in_frame, broken, addr_hit;
  logic [CW-1:0] byte_cnt;
  logic [FRAME_BYTES*8-1:0] store;
  req_fields_t fields_q, fields_d;

  logic start, frame_done, append, accept, st_we;
  logic [AW-1:0] st_addr;

  assign start      = rx_valid & quiet;
  assign frame_done = in_frame & quiet;
  assign append     = rx_valid & in_frame & ~quiet & ~gap_mid;
  assign accept     = ~broken & addr_hit & (byte_cnt == LEN_OK) & crc_zero;
  assign st_we      = start | (append & (byte_cnt < LEN_OK));
  assign st_addr    = start ? '0 : byte_cnt[AW-1:0];

  rtu_silence_timer #(
    .CLKS_PER_BIT(CLKS_PER_BIT),
    .CHAR_BITS   (CHAR_BITS)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .byte_stb(rx_valid),
    .gap_mid (gap_mid),
    .quiet   (quiet)
  );

  rtu_crc16 u_crc (
    .clk (clk),
    .rst (rst),
    .load(start),
    .upd (append & addr_hit),
    .data(rx_data),
    .zero(crc_zero)
  );

  rtu_byte_store #(.DEPTH(FRAME_BYTES)) u_store (
    .clk  (clk),
    .we   (st_we),
    .waddr(st_addr),
    .wdata(rx_data),
    .flat (store)
  );

  // field layout: byte1 func, bytes2..3 start (high first), bytes4..5 word
  assign fields_d.func  = store[1*8 +: 8];
  assign fields_d.start = {store[2*8 +: 8], store[3*8 +: 8]};
  assign fields_d.word  = {store[4*8 +: 8], store[5*8 +: 8]};

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame    <= 1'b0;
      broken      <= 1'b0;
      addr_hit    <= 1'b0;
      byte_cnt    <= '0;
      frame_valid <= 1'b0;
      fields_q    <= '0;
    end else begin
      frame_valid <= 1'b0;
      if (frame_done) begin
        in_frame <= 1'b0;
        if (accept) begin
          frame_valid <= 1'b1;
          fields_q    <= fields_d;
        end
      end
      if (start) begin
        in_frame <= 1'b1;
        broken   <= 1'b0;
        addr_hit <= (rx_data == slave_addr);
        byte_cnt <= CW'(1);
      end else if (rx_valid && in_frame) begin
        if (gap_mid)               broken   <= 1'b1;
        else if (byte_cnt <= LEN_OK) byte_cnt <= byte_cnt + 1'b1;
      end
    end
  end

  assign func_code = fields_q.func;
  assign start_reg = fields_q.start;
  assign reg_word  = fields_q.word;

endmodule

// File: rtl/rtu_req_rx_chk.sv
module rtu_req_rx_chk #(
  parameter int CLKS_PER_BIT = 8,
  parameter int CHAR_BITS    = 11
) (
  input logic        clk,
  input logic        rst,
  input logic [7:0]  slave_addr,
  input logic [7:0]  rx_data,
  input logic        rx_valid,
  input logic        frame_valid,
  input logic [7:0]  func_code,
  input logic [15:0] start_reg,
  input logic [15:0] reg_word
);
  localparam int T15C = ((CHAR_BITS * 3 + 1) / 2) * CLKS_PER_BIT;
  localparam int T35C = ((CHAR_BITS * 7 + 1) / 2) * CLKS_PER_BIT;
  localparam int SW   = $clog2(T35C + 2);
  localparam logic [SW-1:0] T15_L = SW'(T15C);
  localparam logic [SW-1:0] T35_L = SW'(T35C);

  logic [SW-1:0] since;
  logic          taint, prev_taint;
  logic [7:0]    faddr, prev_addr;
  logic [3:0]    flen, prev_len;
  logic          new_frm, mid_gap;

  assign new_frm = rx_valid && (since >= T35_L);
  assign mid_gap = rx_valid && (since >= T15_L) && (since < T35_L);

  always_ff @(posedge clk) begin
    if (rst) begin
      since <= T35_L;
      taint <= 1'b0;
      faddr <= '0;
      flen  <= '0;
    end else begin
      if (rx_valid)            since <= '0;
      else if (since != T35_L) since <= since + 1'b1;
      if (new_frm) begin
        taint <= 1'b0;
        faddr <= rx_data;
        flen  <= 4'd1;
      end else if (rx_valid) begin
        if (mid_gap) taint <= 1'b1;
        if (flen != 4'hF) flen <= flen + 1'b1;
      end
    end
    prev_taint <= taint;
    prev_addr  <= faddr;
    prev_len   <= flen;
  end

  // R2
  pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> !frame_valid);

  // R3
  silence_before_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> since >= T35_L);

  // R6
  no_broken_accept_chk: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> !prev_taint);

  // R4
  addr_match_chk: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> prev_addr == slave_addr);

  // R7
  exact_len_chk: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> prev_len == 4'd8);

  // R5
  fields_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_valid |-> ($stable(func_code) && $stable(start_reg) && $stable(reg_word)));

endmodule

bind rtu_req_rx rtu_req_rx_chk #(
  .CLKS_PER_BIT(CLKS_PER_BIT),
  .CHAR_BITS   (CHAR_BITS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .slave_addr (slave_addr),
  .rx_data    (rx_data),
  .rx_valid   (rx_valid),
  .frame_valid(frame_valid),
  .func_code  (func_code),
  .start_reg  (start_reg),
  .reg_word   (reg_word)
);

// File: tb/rtu_req_rx_test.sv
`timescale 1ns/1ps
module rtu_req_rx_test;
  localparam int CPB   = 4;
  localparam int SPACE = 44;            // one 11-bit character
  localparam int T35C  = 39 * CPB;      // 156 clocks
  localparam int IDLE  = 200;

  typedef struct packed {
    logic [7:0]  addr;
    logic [7:0]  fc;
    logic [15:0] a;
    logic [15:0] b;
    logic        bad_crc;
    logic        exp;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'h11, 8'h03, 16'h0001, 16'h0001, 1'b0, 1'b1},
    '{8'h11, 8'h04, 16'h0001, 16'h0004, 1'b0, 1'b1},
    '{8'h11, 8'h06, 16'h0001, 16'h0017, 1'b0, 1'b1},
    '{8'h11, 8'h03, 16'h0002, 16'h0001, 1'b1, 1'b0},
    '{8'h22, 8'h04, 16'h0003, 16'h0002, 1'b0, 1'b0},
    '{8'h10, 8'h03, 16'h0001, 16'h0001, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  slave_addr = 8'h11;
  logic [7:0]  rx_data = 8'h00;
  logic        rx_valid = 1'b0;
  logic        frame_valid;
  logic [7:0]  func_code;
  logic [15:0] start_reg, reg_word;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  int cycles = 0;
  logic [7:0] fb [16];

  always #2.5 clk = ~clk;

  rtu_req_rx #(.CLKS_PER_BIT(CPB)) uut (
    .clk(clk), .rst(rst), .slave_addr(slave_addr),
    .rx_data(rx_data), .rx_valid(rx_valid),
    .frame_valid(frame_valid), .func_code(func_code),
    .start_reg(start_reg), .reg_word(reg_word)
  );

  always @(negedge clk) if (frame_valid) pulses++;

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      c ^= {8'h00, fb[i]};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
    end
    return c;
  endfunction

  task automatic build(input logic [7:0] ad, input logic [7:0] fc,
                       input logic [15:0] a, input logic [15:0] b);
    logic [15:0] c;
    fb[0] = ad; fb[1] = fc; fb[2] = a[15:8]; fb[3] = a[7:0];
    fb[4] = b[15:8]; fb[5] = b[7:0];
    c = ref_crc(6);
    fb[6] = c[7:0]; fb[7] = c[15:8];
  endtask

  task automatic send(input int n, input int brk_at, input int brk_gap);
    for (int i = 0; i < n; i++) begin
      int g;
      g = (i == brk_at) ? brk_gap : SPACE;
      repeat (g - 1) @(negedge clk);
      rx_data = fb[i]; rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0;
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_frame(input string req, input logic e,
                              input logic [7:0] fc, input logic [15:0] a, input logic [15:0] b);
    int p0;
    logic [7:0] f0; logic [15:0] s0, w0;
    p0 = pulses; f0 = func_code; s0 = start_reg; w0 = reg_word;
    repeat (IDLE) @(negedge clk);
    chk(req, pulses - p0, e ? 1 : 0);
    if (e) begin
      chk(req, {24'h0, func_code}, {24'h0, fc});
      chk(req, {16'h0, start_reg}, {16'h0, a});
      chk(req, {16'h0, reg_word},  {16'h0, b});
    end else begin
      chk(req, {func_code, start_reg, reg_word}, {f0, s0, w0});
    end
  endtask

  initial begin
    // R1 reset state
    repeat (4) @(negedge clk);
    chk("R1", {7'h0, frame_valid, func_code, start_reg}, 0);
    chk("R1", {16'h0, reg_word}, 0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    chk("R1", {7'h0, frame_valid, func_code, start_reg}, 0);

    // table: R2 R4 R5 (first entry right after reset also covers R1)
    for (int v = 0; v < NV; v++) begin
      build(VECS[v].addr, VECS[v].fc, VECS[v].a, VECS[v].b);
      if (VECS[v].bad_crc) fb[7] = fb[7] ^ 8'h01;
      send(8, -1, 0);
      expect_frame(VECS[v].bad_crc ? "R5" : (VECS[v].exp ? "R2" : "R4"),
                   VECS[v].exp, VECS[v].fc, VECS[v].a, VECS[v].b);
    end

    // R3 timing window after the last byte
    begin
      int p0;
      build(8'h11, 8'h03, 16'h0001, 16'h0451);
      p0 = pulses;
      send(8, -1, 0);
      repeat (T35C - 8) @(negedge clk);
      chk("R3 early", pulses - p0, 0);
      repeat (20) @(negedge clk);
      chk("R3 late", pulses - p0, 1);
      chk("R3", {16'h0, reg_word}, 32'h0451);
      repeat (IDLE) @(negedge clk);
    end

    // R6 gap in broken zone, then gap just under the threshold
    build(8'h11, 8'h04, 16'h0002, 16'h0003);
    send(8, 4, 100);
    expect_frame("R6 broken", 1'b0, 8'h0, 16'h0, 16'h0);
    send(8, 4, 66);
    expect_frame("R6 near", 1'b1, 8'h04, 16'h0002, 16'h0003);

    // R7 one byte too many, one frame too short with valid residue
    build(8'h11, 8'h03, 16'h0001, 16'h0001);
    fb[8] = 8'h00;
    send(9, -1, 0);
    expect_frame("R7 long", 1'b0, 8'h0, 16'h0, 16'h0);
    begin
      logic [15:0] c;
      fb[0] = 8'h11; fb[1] = 8'h03; fb[2] = 8'h00; fb[3] = 8'h01;
      c = ref_crc(4);
      fb[4] = c[7:0]; fb[5] = c[15:8];
      send(6, -1, 0);
      expect_frame("R7 short", 1'b0, 8'h0, 16'h0, 16'h0);
    end

    // R8 address from the port
    slave_addr = 8'h22;
    build(8'h22, 8'h06, 16'h0001, 16'h0005);
    send(8, -1, 0);
    expect_frame("R8 new", 1'b1, 8'h06, 16'h0001, 16'h0005);
    build(8'h11, 8'h03, 16'h0001, 16'h0001);
    send(8, -1, 0);
    expect_frame("R8 old", 1'b0, 8'h0, 16'h0, 16'h0);
    slave_addr = 8'h11;

    // R9 stray byte, silence, then a clean frame
    fb[0] = 8'h11;
    send(1, -1, 0);
    repeat (IDLE) @(negedge clk);
    build(8'h11, 8'h04, 16'h0001, 16'h0002);
    send(8, -1, 0);
    expect_frame("R9", 1'b1, 8'h04, 16'h0001, 16'h0002);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule